// File: doc/BRIEF.md
# Infrared Clicker Packet Decoder

This block turns the demodulated infrared envelope of a handheld response clicker into decoded button presses. The input is a single synchronised level, 1 while light is present. Each press sends two bursts about 9 ms apart. Every data bit is carried by three chips of fixed length: a low chip, a high chip and then the data chip. Each burst holds 36 data bits: a button code, a transmitter identity and a checksum. The second burst repeats the first with every data bit inverted, while the low/high delimiter chips are sent unchanged.

The decoder times its chips from the first rising edge of a burst and samples each chip at its middle. It rejects any burst whose delimiter chips are wrong. It checks the first burst's checksum and button code, then compares the second burst against the inverse of the first. It reports either a one-clock valid strobe with the button number and identity, or a one-clock error strobe.

The results leave through a strobe without a ready input, because the infrared line cannot be paused. A consumer must capture `button_num` and `xmit_id` in the cycle where `pkt_valid` is high. Both fields then hold their values until the next valid strobe.

Top module: `ir_clicker_decoder`

## Requirements
- R1: While reset is active, and afterwards until the first decoded press, `pkt_valid` and `pkt_err` are 0 and `button_num` and `xmit_id` are 0.
- R2: A burst is framed as follows. Chip timing starts at the first rising edge of the line, and each chip is sampled at its middle. Every bit is a low chip, a high chip and a data chip. Bits arrive most significant first. The 36-bit word is a 4-bit button code, then the 24-bit identity, then the 8-bit checksum.
- R3: If a delimiter chip reads high where low is due, or low where high is due, in either burst, `pkt_err` pulses and no valid strobe is given for that press.
- R4: The checksum must equal the sum, modulo 256, of the button code (zero-extended) and the three identity bytes. A mismatch in the first burst gives `pkt_err`.
- R5: The top bit of the button code must be 1, and its low three bits (the button number) must lie in 1..6. Otherwise `pkt_err` pulses.
- R6: Each data bit of the second burst must be the complement of the same bit in the first burst. Any difference gives `pkt_err`.
- R7: If no rising edge starts a second burst within `GAP_TIMEOUT_CHIPS` chip periods after the first burst's last data sample, `pkt_err` pulses. A second burst that starts inside that window is accepted.
- R8: `pkt_valid` pulses for one clock only after both bursts pass every check. It carries `button_num` (the low three code bits) and `xmit_id` from the first burst. Both hold until the next valid strobe.
- R9: `pkt_valid` and `pkt_err` are never high together. Each is a single-clock pulse, and each press attempt yields at most one of them.
- R10: After any outcome the decoder rearms once the line has stayed low for `QUIET_CHIPS` chip periods. A press that follows then decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_level | input | 1 | Synchronised demodulated infrared level, 1 = light |
| pkt_valid | output | 1 | One-clock strobe: a press decoded and verified |
| button_num | output | 3 | Button number 1..6 of the last verified press |
| xmit_id | output | 24 | Transmitter identity of the last verified press |
| pkt_err | output | 1 | One-clock strobe: a press attempt failed a check |

## Verification
Good presses are sent with different button codes and identities. These include an identity whose byte sum wraps past 255 and the all-ones identity. They separate correct bit ordering and field splitting from a decoder that merely accepts anything. Single corrupted features are each sent alone:
- a checksum off by one;
- a button code with the top bit low, or a number outside 1..6;
- a flipped bit in the second burst, or a second burst sent uninverted;
- a bad low or high delimiter chip in either burst;
- a missing second burst.

Each of these must map to exactly one error strobe, and the held outputs must be left untouched. A late second burst that is still inside the timeout, and a good press sent right after an error, show that the decoder resynchronises rather than staying blocked.

// File: rtl/irpd_pkg.sv
`timescale 1ns/100ps
package irpd_pkg;
  localparam int BTN_W    = 4;
  localparam int ID_W     = 24;
  localparam int SUM_W    = 8;
  localparam int PKT_W    = BTN_W + ID_W + SUM_W;
  localparam int ID_BYTES = ID_W / 8;
  localparam int NUM_W    = BTN_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PKT1,
    ST_GAP,
    ST_PKT2,
    ST_RECOVER
  } dec_state_e;

  typedef enum logic [1:0] {
    PH_LOW,
    PH_HIGH,
    PH_DATA
  } chip_phase_e;

  typedef struct packed {
    logic [BTN_W-1:0] code;
    logic [ID_W-1:0]  id;
    logic [SUM_W-1:0] sum;
  } pkt_word_t;
endpackage

// File: rtl/irpd_chip_timer.sv
`timescale 1ns/100ps
// Counts clocks inside a chip and flags the middle of each chip.
module irpd_chip_timer #(
  parameter int CHIP_CLKS = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic sample_stb
);
  localparam int CW  = $clog2(CHIP_CLKS + 1);
  localparam int MID = CHIP_CLKS / 2;

  logic [CW-1:0] cnt_q;

  // The start cycle is clock 0 of the first observed chip.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(1);
    end else if (run) begin
      if (cnt_q == CW'(CHIP_CLKS - 1)) cnt_q <= '0;
      else                             cnt_q <= cnt_q + CW'(1);
    end
  end

  assign sample_stb = run && !start && (cnt_q == CW'(MID));
endmodule

// File: rtl/irpd_delim_slicer.sv
`timescale 1ns/100ps
// Walks the low/high/data chip pattern and flags delimiter faults.
module irpd_delim_slicer
  import irpd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sample_stb,
  input  logic lvl,
  output logic bit_stb,
  output logic bit_val,
  output logic delim_err
);
  chip_phase_e phase_q;

  // A burst is caught at its first rise, i.e. in the high chip of bit 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOW;
    end else if (start) begin
      phase_q <= PH_HIGH;
    end else if (sample_stb) begin
      case (phase_q)
        PH_LOW:  phase_q <= PH_HIGH;
        PH_HIGH: phase_q <= PH_DATA;
        default: phase_q <= PH_LOW;
      endcase
    end
  end

  assign bit_stb   = sample_stb && (phase_q == PH_DATA);
  assign bit_val   = lvl;
  assign delim_err = sample_stb &&
                     (((phase_q == PH_LOW) && lvl) || ((phase_q == PH_HIGH) && !lvl));
endmodule

// File: rtl/irpd_word_collect.sv
`timescale 1ns/100ps
// Shifts data bits in, most significant first, and marks the last one.
module irpd_word_collect #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         bit_stb,
  input  logic         bit_val,
  output logic         word_done,
  output logic [W-1:0] word
);
  localparam int CW = $clog2(W + 1);

  logic [W-2:0]  shreg_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (start) begin
      cnt_q <= '0;
    end else if (bit_stb) begin
      shreg_q <= {shreg_q[W-3:0], bit_val};
      cnt_q   <= cnt_q + CW'(1);
    end
  end

  assign word_done = bit_stb && (cnt_q == CW'(W - 1));
  assign word      = {shreg_q, bit_val};
endmodule

// File: rtl/irpd_pkt_check.sv
`timescale 1ns/100ps
// Content checks: code sanity, byte-sum checksum, inverse match.
module irpd_pkt_check
  import irpd_pkg::*;
(
  input  pkt_word_t cand,
  input  pkt_word_t held,
  output logic      first_ok,
  output logic      inv_match
);
  logic [SUM_W-1:0] part [ID_BYTES+1];
  logic [NUM_W-1:0] num;
  logic             sum_ok;
  logic             code_ok;

  assign part[0] = SUM_W'(cand.code);

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_bytesum
    assign part[g+1] = part[g] + cand.id[g*8 +: 8];
  end

  assign sum_ok    = (part[ID_BYTES] == cand.sum);
  assign num       = cand.code[NUM_W-1:0];
  assign code_ok   = cand.code[BTN_W-1] && (num != '0) && (num != '1);
  assign first_ok  = sum_ok && code_ok;
  assign inv_match = (cand == ~held);
endmodule

// File: rtl/ir_clicker_decoder.sv
`timescale 1ns/100ps
module ir_clicker_decoder
  import irpd_pkg::*;
#(
  parameter int CHIP_CLKS         = 100000,
  parameter int GAP_TIMEOUT_CHIPS = 40,
  parameter int QUIET_CHIPS       = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_level,
  output logic        pkt_valid,
  output logic [2:0]  button_num,
  output logic [23:0] xmit_id,
  output logic        pkt_err
);
  localparam int GAP_CLKS   = GAP_TIMEOUT_CHIPS * CHIP_CLKS;
  localparam int QUIET_CLKS = QUIET_CHIPS * CHIP_CLKS;
  localparam int GCW        = $clog2(GAP_CLKS + 1);
  localparam int QCW        = $clog2(QUIET_CLKS + 1);

  logic            lvl_q, lvl_prev_q, rise;
  dec_state_e      state_q;
  logic            start, in_pkt, sample_stb;
  logic            bit_stb, bit_val, delim_err;
  logic            word_done;
  logic [PKT_W-1:0] word;
  pkt_word_t       word_s, first_q;
  logic            first_ok, inv_match;
  logic [GCW-1:0]  gap_cnt_q;
  logic [QCW-1:0]  quiet_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q      <= 1'b0;
      lvl_prev_q <= 1'b0;
    end else begin
      lvl_q      <= ir_level;
      lvl_prev_q <= lvl_q;
    end
  end

  assign rise   = lvl_q && !lvl_prev_q;
  assign start  = rise && ((state_q == ST_IDLE) || (state_q == ST_GAP));
  assign in_pkt = (state_q == ST_PKT1) || (state_q == ST_PKT2);
  assign word_s = word;

  irpd_chip_timer #(.CHIP_CLKS(CHIP_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .run(in_pkt), .sample_stb(sample_stb)
  );

  irpd_delim_slicer u_slicer (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_stb(sample_stb), .lvl(lvl_q),
    .bit_stb(bit_stb), .bit_val(bit_val), .delim_err(delim_err)
  );

  irpd_word_collect #(.W(PKT_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_stb(bit_stb), .bit_val(bit_val),
    .word_done(word_done), .word(word)
  );

  irpd_pkt_check u_check (
    .cand(word_s), .held(first_q), .first_ok(first_ok), .inv_match(inv_match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      first_q     <= '0;
      gap_cnt_q   <= '0;
      quiet_cnt_q <= '0;
      pkt_valid   <= 1'b0;
      pkt_err     <= 1'b0;
      button_num  <= '0;
      xmit_id     <= '0;
    end else begin
      pkt_valid <= 1'b0;
      pkt_err   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) state_q <= ST_PKT1;
        end
        ST_PKT1: begin
          if (delim_err) begin
            pkt_err     <= 1'b1;
            quiet_cnt_q <= '0;
            state_q     <= ST_RECOVER;
          end else if (word_done) begin
            if (first_ok) begin
              first_q   <= word_s;
              gap_cnt_q <= '0;
              state_q   <= ST_GAP;
            end else begin
              pkt_err     <= 1'b1;
              quiet_cnt_q <= '0;
              state_q     <= ST_RECOVER;
            end
          end
        end
        ST_GAP: begin
          if (start) begin
            state_q <= ST_PKT2;
          end else if (gap_cnt_q == GCW'(GAP_CLKS - 1)) begin
            pkt_err     <= 1'b1;
            quiet_cnt_q <= '0;
            state_q     <= ST_RECOVER;
          end else begin
            gap_cnt_q <= gap_cnt_q + GCW'(1);
          end
        end
        ST_PKT2: begin
          if (delim_err) begin
            pkt_err     <= 1'b1;
            quiet_cnt_q <= '0;
            state_q     <= ST_RECOVER;
          end else if (word_done) begin
            if (inv_match) begin
              pkt_valid  <= 1'b1;
              button_num <= first_q.code[NUM_W-1:0];
              xmit_id    <= first_q.id;
            end else begin
              pkt_err <= 1'b1;
            end
            quiet_cnt_q <= '0;
            state_q     <= ST_RECOVER;
          end
        end
        default: begin
          if (lvl_q) begin
            quiet_cnt_q <= '0;
          end else if (quiet_cnt_q == QCW'(QUIET_CLKS - 1)) begin
            state_q <= ST_IDLE;
          end else begin
            quiet_cnt_q <= quiet_cnt_q + QCW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/irpd_checker.sv
`timescale 1ns/100ps
module irpd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        pkt_valid,
  input logic        pkt_err,
  input logic [2:0]  button_num,
  input logic [23:0] xmit_id,
  input logic        delim_err,
  input logic        in_pkt
);
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_valid && pkt_err));

  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_err |=> !pkt_err);

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> !pkt_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> ($stable(button_num) && $stable(xmit_id)));

  p_num_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> ((button_num != 3'd0) && (button_num != 3'd7)));

  p_delim_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt && delim_err) |=> (pkt_err && !pkt_valid));
endmodule

bind ir_clicker_decoder irpd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_err(pkt_err),
  .button_num(button_num), .xmit_id(xmit_id), .delim_err(delim_err), .in_pkt(in_pkt)
);

// File: tb/ir_clicker_decoder_test.sv
`timescale 1ns/100ps
module ir_clicker_decoder_test;
  localparam int CHIP      = 16;
  localparam int GAPT      = 36;
  localparam int QUIET     = 6;
  localparam int GAP_CHIPS = 18;

  logic clk = 1'b0, rst_n = 1'b0, ir = 1'b0;
  logic        pkt_valid, pkt_err;
  logic [2:0]  button_num;
  logic [23:0] xmit_id;

  always #2.5 clk = ~clk;

  ir_clicker_decoder #(.CHIP_CLKS(CHIP), .GAP_TIMEOUT_CHIPS(GAPT), .QUIET_CHIPS(QUIET)) uut (
    .clk(clk), .rst_n(rst_n), .ir_level(ir), .pkt_valid(pkt_valid),
    .button_num(button_num), .xmit_id(xmit_id), .pkt_err(pkt_err)
  );

  typedef struct { bit is_err; logic [2:0] btn; logic [23:0] id; string tag; } exp_t;
  exp_t expq[$];
  exp_t cur;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [35:0] mkpkt(input logic [3:0] code, input logic [23:0] id,
                                        input int adj);
    logic [7:0] s;
    s = 8'(code) + id[23:16] + id[15:8] + id[7:0] + 8'(adj);
    return {code, id, s};
  endfunction

  task automatic chip(input logic v);
    ir = v;
    repeat (CHIP) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) chip(1'b0);
  endtask

  // bad_bit >= 0 corrupts one delimiter: low chip if !bad_hi, else high chip.
  task automatic send_word(input logic [35:0] w, input int bad_bit, input bit bad_hi);
    for (int i = 35; i >= 0; i--) begin
      chip((i == bad_bit && !bad_hi) ? 1'b1 : 1'b0);
      chip((i == bad_bit && bad_hi) ? 1'b0 : 1'b1);
      chip(w[i]);
    end
    ir = 1'b0;
  endtask

  task automatic pair(input logic [35:0] w, input logic [35:0] flip, input int gap,
                      input int bad2, input bit bad2_hi);
    send_word(w, -1, 1'b0);
    idle(gap);
    send_word(~w ^ flip, bad2, bad2_hi);
    idle(QUIET + 4);
  endtask

  task automatic expect_ok(input logic [2:0] b, input logic [23:0] id, input string tag);
    exp_t e;
    e.is_err = 1'b0; e.btn = b; e.id = id; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic expect_err(input string tag);
    exp_t e;
    e.is_err = 1'b1; e.btn = '0; e.id = '0; e.tag = tag;
    expq.push_back(e);
  endtask

  // Monitor: scoreboard pops one expected item per strobe.
  always @(negedge clk) begin
    if (rst_n && (pkt_valid || pkt_err)) begin
      if (expq.size() == 0) begin
        check(1'b0, "R9", "unexpected strobe", 32'({pkt_valid, pkt_err}), 32'd0);
      end else begin
        cur = expq.pop_front();
        if (cur.is_err) begin
          check(pkt_err && !pkt_valid, cur.tag, "error strobe",
                32'({pkt_valid, pkt_err}), 32'd1);
        end else begin
          check(pkt_valid && !pkt_err, cur.tag, "valid strobe",
                32'({pkt_valid, pkt_err}), 32'd2);
          check(button_num == cur.btn, cur.tag, "button_num",
                32'(button_num), 32'(cur.btn));
          check(xmit_id == cur.id, cur.tag, "xmit_id", 32'(xmit_id), 32'(cur.id));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", expq.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(!pkt_valid && !pkt_err, "R1", "strobes in reset", 32'({pkt_valid, pkt_err}), 32'd0);
    check(button_num == 3'd0 && xmit_id == 24'd0, "R1", "fields in reset",
          32'(xmit_id), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!pkt_valid && !pkt_err && button_num == 3'd0, "R1", "idle after reset",
          32'({pkt_valid, pkt_err, button_num}), 32'd0);
    idle(2);

    // R2 R4 R8: button A, identity 55573
    expect_ok(3'd1, 24'h00D915, "R2");
    pair(mkpkt(4'b1001, 24'h00D915, 0), '0, GAP_CHIPS, -1, 1'b0);
    // R4: byte sum wraps past 255
    expect_ok(3'd5, 24'hABCDEF, "R4");
    pair(mkpkt(4'b1101, 24'hABCDEF, 0), '0, GAP_CHIPS, -1, 1'b0);
    // R5 boundary: highest legal number, all-ones identity
    expect_ok(3'd6, 24'hFFFFFF, "R5");
    pair(mkpkt(4'b1110, 24'hFFFFFF, 0), '0, GAP_CHIPS, -1, 1'b0);

    // R4: checksum off by one, first burst only
    expect_err("R4");
    send_word(mkpkt(4'b1010, 24'h123456, 1), -1, 1'b0);
    idle(QUIET + 4);
    check(button_num == 3'd6 && xmit_id == 24'hFFFFFF, "R8", "held fields after error",
          32'(xmit_id), 32'hFFFFFF);

    // R5: leading bit low, number 7, number 0
    expect_err("R5");
    send_word(mkpkt(4'b0011, 24'h010203, 0), -1, 1'b0);
    idle(QUIET + 4);
    expect_err("R5");
    send_word(mkpkt(4'b1111, 24'h010203, 0), -1, 1'b0);
    idle(QUIET + 4);
    expect_err("R5");
    send_word(mkpkt(4'b1000, 24'h010203, 0), -1, 1'b0);
    idle(QUIET + 4);

    // R6: one flipped bit in second burst; second burst uninverted
    expect_err("R6");
    pair(mkpkt(4'b1011, 24'h0F0F0F, 0), 36'd1, GAP_CHIPS, -1, 1'b0);
    expect_err("R6");
    pair(mkpkt(4'b1100, 24'h5A5A5A, 0), '1, GAP_CHIPS, -1, 1'b0);

    // R3: low delimiter driven high in first burst; high delimiter driven low in second
    expect_err("R3");
    send_word(mkpkt(4'b1001, 24'h00D915, 0), 20, 1'b0);
    idle(QUIET + 4);
    expect_err("R3");
    pair(mkpkt(4'b1101, 24'h3C3C3C, 0), '0, GAP_CHIPS, 5, 1'b1);

    // R7: missing second burst
    expect_err("R7");
    send_word(mkpkt(4'b1010, 24'h777777, 0), -1, 1'b0);
    idle(GAPT + QUIET + 6);
    // R7: late second burst still inside the window
    expect_ok(3'd3, 24'h246801, "R7");
    pair(mkpkt(4'b1011, 24'h246801, 0), '0, GAPT - 6, -1, 1'b0);

    // R10: error then a press right after the quiet time
    expect_err("R10");
    send_word(mkpkt(4'b1100, 24'h000001, 2), -1, 1'b0);
    idle(QUIET + 2);
    expect_ok(3'd4, 24'h000001, "R10");
    pair(mkpkt(4'b1100, 24'h000001, 0), '0, GAP_CHIPS, -1, 1'b0);

    idle(4);
    check(expq.size() == 0, "R9", "outstanding expected strobes", 32'(expq.size()), 32'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule